// File: doc/BRIEF.md
# ATM Cell Header Check and Payload Scrambler Stage

This transmit pipeline stage takes 53-octet ATM cells as a byte stream, one octet per clock, with a start-of-cell marker and a valid/ready handshake. It computes the header error control octet over the first four header octets and writes it into the fifth octet. The payload then goes through a self-synchronizing scrambler. The result leaves the stage on an identical byte-stream interface after one register stage.

The check octet is a CRC-8 with generator x^8 + x^2 + x + 1, added modulo 2 to the coset 0x55. The scrambler XORs each payload bit with the scrambler output bit from 43 payload bit-times earlier. E1 links use it. On T1 links a configuration input turns it off and the payload passes through unchanged. Header octets never reach the scrambler.

Top module: `atm_cell_tx_stage`

## Requirements
- R1: The output octet at cell position 4 (the fifth octet, counting from 0) equals CRC-8 over input octets 0 to 3, XORed with 0x55. The CRC uses polynomial 0x107, starts at zero for every cell and takes each octet MSB first. A header of 00 00 00 01 gives 0x52.
- R2: The value of input octet 4 has no effect on the output cell.
- R3: Output octets 0 to 3 equal the input octets 0 to 3.
- R4: With scr_en_i high, payload octets 5 to 52 are scrambled. Taking bits MSB first, each output bit is the input bit XOR the scrambled output bit 43 payload bit-times earlier. The history starts at zero after reset, carries over from one cell to the next, and does not move during header octets.
- R5: With scr_en_i low, payload octets pass unchanged and the scrambler history holds its value. When scrambling is turned back on, it continues from the held history.
- R6: An octet accepted while the output is not stalled appears on the output in the next cycle.
- R7: in_ready_o is high whenever the output register is empty or out_ready_i is high. While out_valid_o is high and out_ready_i is low, the output octet stays stable. No octet is lost or duplicated.
- R8: out_sop_o is high with the first octet of each cell. After reset, out_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scr_en_i | input | 1 | 1: scramble the payload, 0: pass it unchanged |
| in_valid_i | input | 1 | Input octet valid |
| in_sop_i | input | 1 | Input octet is the first of a cell |
| in_data_i | input | 8 | Input octet |
| in_ready_o | output | 1 | The stage accepts an input octet |
| out_valid_o | output | 1 | Output octet valid |
| out_sop_o | output | 1 | Output octet is the first of a cell |
| out_data_o | output | 8 | Output octet |
| out_ready_i | input | 1 | The downstream stage accepts the output octet |

## Verification
The assertions assume the input arrives as complete 53-octet cells, with in_sop_i high on the first octet of each cell only. They also assume scr_en_i is stable over a cell's payload. The stimulus sends only whole cells and changes scr_en_i only between cells. It holds in_valid_i and the input octet steady until each handshake completes. Back-pressure follows a fixed on/off pattern on out_ready_i that never stays low for long.

// File: rtl/atm_txc_pkg.sv
package atm_txc_pkg;
  localparam logic [7:0] HEC_POLY  = 8'h07;  // x^8 + x^2 + x + 1, top bit implied
  localparam logic [7:0] HEC_COSET = 8'h55;

  function automatic logic [7:0] crc8_byte(input logic [7:0] crc, input logic [7:0] d);
    logic [7:0] c;
    c = crc;
    for (int i = 7; i >= 0; i--) begin
      if (c[7] ^ d[i]) c = {c[6:0], 1'b0} ^ HEC_POLY;
      else             c = {c[6:0], 1'b0};
    end
    return c;
  endfunction
endpackage

// File: rtl/atm_hec_gen.sv
module atm_hec_gen
  import atm_txc_pkg::*;
#(
  parameter logic [7:0] COSET = HEC_COSET
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic       first_i,
  input  logic [7:0] data_i,
  output logic [7:0] hec_o
);
  logic [7:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '0;
    else if (step_i) crc_q <= crc8_byte(first_i ? 8'h00 : crc_q, data_i);
  end

  assign hec_o = crc_q ^ COSET;

  // CRC only moves on header octets
  p_crc_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(crc_q)) else $error("crc moved without header octet");
endmodule

// File: rtl/atm_payload_scrambler.sv
module atm_payload_scrambler #(
  parameter int unsigned LAG = 43
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic [7:0] data_i,
  output logic [7:0] data_o
);
  logic [LAG-1:0] hist_q, hist_d;
  logic [7:0]     scr;

  always_comb begin
    logic [LAG-1:0] h;
    h = hist_q;
    for (int i = 7; i >= 0; i--) begin
      scr[i] = data_i[i] ^ h[LAG-1];
      h      = {h[LAG-2:0], scr[i]};
    end
    hist_d = h;
  end

  assign data_o = scr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hist_q <= '0;
    else if (step_i) hist_q <= hist_d;
  end

  p_hist_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(hist_q)) else $error("scrambler history moved while idle");
endmodule

// File: rtl/atm_cell_tx_stage.sv
module atm_cell_tx_stage
  import atm_txc_pkg::*;
#(
  parameter int unsigned CELL_OCTETS = 53,
  parameter int unsigned HEC_IDX     = 4,
  parameter int unsigned SCR_LAG     = 43
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scr_en_i,
  input  logic       in_valid_i,
  input  logic       in_sop_i,
  input  logic [7:0] in_data_i,
  output logic       in_ready_o,
  output logic       out_valid_o,
  output logic       out_sop_o,
  output logic [7:0] out_data_o,
  input  logic       out_ready_i
);
  localparam int unsigned PW = $clog2(CELL_OCTETS);
  localparam logic [PW-1:0] HEC_P  = PW'(HEC_IDX);
  localparam logic [PW-1:0] LAST_P = PW'(CELL_OCTETS - 1);

  logic [PW-1:0] cnt_q, pos;
  logic          accept, is_hdr, is_hec, is_pl;
  logic [7:0]    hec, scr_data, sel_data;
  logic          out_valid_q, out_sop_q;
  logic [7:0]    out_data_q;

  assign pos        = in_sop_i ? '0 : cnt_q;
  assign is_hdr     = pos < HEC_P;
  assign is_hec     = pos == HEC_P;
  assign is_pl      = pos > HEC_P;
  assign in_ready_o = ~out_valid_q | out_ready_i;
  assign accept     = in_valid_i & in_ready_o;

  atm_hec_gen i_hec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (accept & is_hdr),
    .first_i(pos == '0),
    .data_i (in_data_i),
    .hec_o  (hec)
  );

  atm_payload_scrambler #(.LAG(SCR_LAG)) i_scr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (accept & is_pl & scr_en_i),
    .data_i (in_data_i),
    .data_o (scr_data)
  );

  always_comb begin
    if (is_hec)                 sel_data = hec;
    else if (is_pl && scr_en_i) sel_data = scr_data;
    else                        sel_data = in_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (accept) cnt_q <= (pos == LAST_P) ? '0 : pos + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      out_sop_q   <= 1'b0;
      out_data_q  <= '0;
    end else if (in_ready_o) begin
      out_valid_q <= in_valid_i;
      if (accept) begin
        out_sop_q  <= in_sop_i;
        out_data_q <= sel_data;
      end
    end
  end

  assign out_valid_o = out_valid_q;
  assign out_sop_o   = out_sop_q;
  assign out_data_o  = out_data_q;

  p_header_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && is_hdr |=> out_data_o == $past(in_data_i)) else $error("header octet altered");
  p_bypass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && is_pl && !scr_en_i |=> out_data_o == $past(in_data_i)) else $error("bypass altered payload");
  p_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> out_valid_o) else $error("accepted octet not presented");
  p_stall_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_sop_o))
    else $error("output changed under stall");
  p_ready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o) else $error("empty stage not ready");
  p_sop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && in_sop_i |=> out_sop_o) else $error("start of cell lost");
endmodule

// File: tb/test_atm_cell_tx_stage.sv
module test_atm_cell_tx_stage;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scr_en_i = 1'b1;
  logic       in_valid_i = 1'b0;
  logic       in_sop_i = 1'b0;
  logic [7:0] in_data_i = '0;
  logic       in_ready_o, out_valid_o, out_sop_o;
  logic [7:0] out_data_o;
  logic       out_ready_i = 1'b1;

  always #2 clk_i = ~clk_i;

  atm_cell_tx_stage i_atm_cell_tx_stage (
    .clk_i(clk_i), .rst_ni(rst_ni), .scr_en_i(scr_en_i),
    .in_valid_i(in_valid_i), .in_sop_i(in_sop_i), .in_data_i(in_data_i),
    .in_ready_o(in_ready_o), .out_valid_o(out_valid_o), .out_sop_o(out_sop_o),
    .out_data_o(out_data_o), .out_ready_i(out_ready_i)
  );

  int checks = 0, errors = 0, cyc = 0, bp_idx = 0;
  logic [7:0] exp_d[$];
  logic       exp_s[$];
  string      exp_t[$];
  int         exp_c[$];
  logic       bp_on = 1'b0;
  logic [7:0] bp_pat = 8'b1011_0010;
  logic       stall_q = 1'b0;
  logic [7:0] stall_d = '0;
  logic       mhist[43];
  int         mptr = 0;
  logic       mscr = 1'b1;
  logic [7:0] hec_seen[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] hec_of(input logic [31:0] h);
    logic [39:0] m;
    m = {h, 8'h00};
    for (int i = 39; i >= 8; i--) if (m[i]) m[i-:9] = m[i-:9] ^ 9'h107;
    return m[7:0] ^ 8'h55;
  endfunction

  function automatic logic [7:0] scr_model(input logic [7:0] d);
    logic [7:0] o;
    if (!mscr) return d;
    for (int i = 7; i >= 0; i--) begin
      o[i] = d[i] ^ mhist[mptr];
      mhist[mptr] = o[i];
      mptr = (mptr + 1) % 43;
    end
    return o;
  endfunction

  task automatic check_out();
    if (exp_d.size() == 0) begin
      chk(1'b0, "R7 unexpected extra octet", out_data_o, 0);
    end else begin
      logic [7:0] d; logic s; string t; int c;
      d = exp_d.pop_front(); s = exp_s.pop_front(); t = exp_t.pop_front(); c = exp_c.pop_front();
      if (t == "R1 HEC" || t == "R2 octet4 ignored") hec_seen.push_back(out_data_o);
      chk(out_data_o == d, t, out_data_o, d);
      chk(out_sop_o == s, "R8 start of cell", out_sop_o, s);
      if (!bp_on) chk(cyc == c + 1, "R6 latency", cyc, c + 1);
    end
  endtask

  task automatic cycle(output bit acc);
    out_ready_i = bp_on ? bp_pat[bp_idx % 8] : 1'b1;
    bp_idx++;
    #1;
    if (stall_q) chk(out_valid_o && out_data_o == stall_d, "R7 stall hold", out_data_o, stall_d);
    stall_q = out_valid_o && !out_ready_i;
    stall_d = out_data_o;
    acc = in_valid_i && in_ready_o;
    if (out_valid_o && out_ready_i) check_out();
    cyc++;
    @(negedge clk_i);
  endtask

  task automatic push(input logic [7:0] d, input logic s, input logic [7:0] e, input string t);
    bit acc;
    in_valid_i = 1'b1; in_data_i = d; in_sop_i = s;
    do cycle(acc); while (!acc);
    exp_d.push_back(e); exp_s.push_back(s); exp_t.push_back(t); exp_c.push_back(cyc - 1);
    in_valid_i = 1'b0; in_sop_i = 1'b0;
  endtask

  task automatic drain();
    bit acc;
    for (int n = 0; n < 200 && exp_d.size() > 0; n++) cycle(acc);
    chk(exp_d.size() == 0, "R7 octets lost", exp_d.size(), 0);
    bp_on = 1'b0;
    cycle(acc);
  endtask

  task automatic send_cell(input logic [31:0] hdr, input logic [7:0] oct4, input int seed,
                           input string hec_tag, input int hec_fixed);
    logic [7:0] d, e;
    scr_en_i = mscr;
    for (int k = 0; k < 53; k++) begin
      if (k < 4) begin
        d = hdr[31 - 8*k -: 8];
        push(d, k == 0, d, "R3 header");
      end else if (k == 4) begin
        e = (hec_fixed >= 0) ? 8'(hec_fixed) : hec_of(hdr);
        push(oct4, 1'b0, e, hec_tag);
      end else begin
        d = 8'(seed * 37 + k * 13) ^ 8'(k << 3);
        e = scr_model(d);
        push(d, 1'b0, e, mscr ? "R4 payload scrambled" : "R5 payload bypass");
      end
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    @(negedge clk_i); #1;
    chk(out_valid_o == 1'b0, "R8 reset valid low", out_valid_o, 0);
    chk(in_ready_o == 1'b1, "R7 ready when empty", in_ready_o, 1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_known_hec();
    mscr = 1'b1;
    send_cell(32'h0000_0001, 8'hA5, 1, "R1 HEC", 8'h52);
    send_cell(32'h0000_0000, 8'h3C, 2, "R1 HEC", 8'h55);
    drain();
  endtask

  task automatic t_scrambled_stream();
    mscr = 1'b1;
    send_cell(32'h1234_5678, 8'h00, 3, "R1 HEC", -1);
    send_cell(32'hFFFF_FFFF, 8'h11, 4, "R1 HEC", -1);
    send_cell(32'h0A0B_0C0E, 8'h22, 5, "R1 HEC", -1);
    drain();
  endtask

  task automatic t_octet4_ignored();
    hec_seen.delete();
    send_cell(32'h4242_1357, 8'h00, 6, "R2 octet4 ignored", -1);
    send_cell(32'h4242_1357, 8'hFF, 7, "R2 octet4 ignored", -1);
    drain();
    chk(hec_seen.size() == 2 && hec_seen[0] == hec_seen[1], "R2 same HEC",
        hec_seen.size() == 2 ? hec_seen[1] : 8'h00, hec_seen.size() == 2 ? hec_seen[0] : 8'h00);
  endtask

  task automatic t_bypass();
    mscr = 1'b0;
    send_cell(32'h0101_0101, 8'h77, 8, "R1 HEC", -1);
    send_cell(32'h9876_5432, 8'h66, 9, "R1 HEC", -1);
    mscr = 1'b1;  // resumes from held history (R5)
    send_cell(32'h0F0F_F0F0, 8'h55, 10, "R1 HEC", -1);
    drain();
  endtask

  task automatic t_backpressure();
    bp_on = 1'b1;
    send_cell(32'hDEAD_BEEF, 8'h01, 11, "R1 HEC", -1);
    mscr = 1'b0;
    send_cell(32'hCAFE_0001, 8'h02, 12, "R1 HEC", -1);
    mscr = 1'b1;
    send_cell(32'h0000_0001, 8'h03, 13, "R1 HEC", 8'h52);
    drain();
  endtask

  initial begin
    for (int i = 0; i < 43; i++) mhist[i] = 1'b0;
    @(negedge clk_i);
    t_reset();
    t_known_hec();
    t_scrambled_stream();
    t_octet4_ignored();
    t_bypass();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule